// File: doc/BRIEF.md
# Battery Fault LED Supervisor

This block watches the two backup batteries of a memory card and owns the card's 8-bit LED control byte. The byte packs three 2-bit lamp fields: a remove lamp, a fault lamp and a power lamp. A host port can replace a field or flip its low bit. The byte drives three physical lamp outputs, and a shared prescaler generates a slow and a fast blink for them.

On a fixed sampling period the block reads a 4-bit battery status input. It keeps a good/failed state and a failure age for each battery. It raises a per-battery warning when a failure has lasted a programmed number of samples. Whenever a sample changes any battery state or warning, it rewrites the fault lamp field from a fixed priority. A sample that falls due during a host-to-card transfer waits until the transfer ends.

Top module: `batt_led_sup`

## Requirements
- R1: The LED byte carries the remove lamp in bits [3:2], the fault lamp in bits [5:4] and the power lamp in bits [7:6]. Bits [1:0] always read zero, and the byte resets to 0x00.
- R2: A host write with `wr_toggle`=0 loads `wr_val` into the field chosen by `wr_field`, where 0 selects remove, 1 selects fault and 2 selects power. The other fields are unchanged. `wr_field`=3 changes nothing.
- R3: A host write with `wr_toggle`=1 inverts only the low bit of the chosen field. Its high bit and the other fields are unchanged.
- R4: Lamp decode works as follows.
  - Code 0 is off and code 1 is on.
  - Code 2 is the slow flash: lit for 3 of every 8 prescaler steps.
  - Code 3 is the fast flash: lit on alternate steps, 4 of 8.
  - Each prescaler step lasts `FLASH_DIV` cycles.
  - The power lamp swaps codes 0 and 1, so its code 0 is lit.
- R5: Status bit 1 flags a failure of battery 1 and bit 3 a failure of battery 2. Bits 0 and 2 (battery disabled flags) have no effect. A sample falls due once every `TICK_CYCLES` clocks.
- R6: While `xfer_busy` is high, no sample is taken. A due sample is taken on the first clock with `xfer_busy` low. Any number of periods that expire during a transfer yield one pending sample.
- R7: A sample in which a battery's failure flag disagrees with its state flips that state and restarts its age. If the battery became good, its warning is cleared.
- R8: A failed, unwarned battery becomes warned on the `WARN_SAMPLES`-th sample after the sample that failed it, if no change occurred in between. `batt_good` and `batt_warned` bit 0 is battery 1.
- R9: The fault field takes the first matching case:
  - 0 if both batteries are good;
  - otherwise 1 if either battery is warned;
  - otherwise 3 if both have failed;
  - otherwise 2.
- R10: The fault field is rewritten only by a sample that changes a state or a warning; otherwise any value the host wrote stays. When such a sample and a host write to the fault field land on the same clock, the sample wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host field write strobe |
| wr_field | input | 2 | Field select: 0 remove, 1 fault, 2 power |
| wr_toggle | input | 1 | 1: flip field low bit; 0: load `wr_val` |
| wr_val | input | 2 | Field code to load |
| xfer_busy | input | 1 | Host-to-card transfer in progress |
| batt_status | input | 4 | Battery status byte (low nibble) |
| led_byte | output | 8 | LED control byte |
| remove_lamp | output | 1 | Remove lamp drive |
| fault_lamp | output | 1 | Fault lamp drive |
| power_lamp | output | 1 | Power lamp drive |
| batt_good | output | 2 | Per-battery good state |
| batt_warned | output | 2 | Per-battery long-failure warning |

## Verification
A wrong battery state or age shows up on `batt_good`, `batt_warned` and the fault field of `led_byte` on the clock after the sample that acts on it. An off-by-one age counter moves the warning one sample earlier or later, which the sample-exact stimulus catches. The bench aligns each sample by releasing `xfer_busy` for a single clock, so every sample lands on a known edge. The flash generators are checked by counting lit cycles over one full prescaler period.

// File: rtl/batt_led_sup.sv
module batt_led_sup #(
  parameter longint unsigned TICK_CYCLES  = 64'd7_500_000_000,
  parameter int unsigned     WARN_SAMPLES = 300,
  parameter int unsigned     FLASH_DIV    = 31_250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_field,
  input  logic       wr_toggle,
  input  logic [1:0] wr_val,
  input  logic       xfer_busy,
  input  logic [3:0] batt_status,
  output logic [7:0] led_byte,
  output logic       remove_lamp,
  output logic       fault_lamp,
  output logic       power_lamp,
  output logic [1:0] batt_good,
  output logic [1:0] batt_warned
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int AW = $clog2(WARN_SAMPLES + 1);
  localparam int FW = (FLASH_DIV > 1) ? $clog2(FLASH_DIV) : 1;

  logic [TW-1:0] tick_q;
  logic          tick_hit, due_q, sample_go;

  assign tick_hit  = (tick_q == TW'(TICK_CYCLES - 1));
  assign sample_go = due_q & ~xfer_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      due_q  <= 1'b0;
    end else begin
      tick_q <= tick_hit ? '0 : tick_q + 1'b1;
      due_q  <= tick_hit | (due_q & ~sample_go);
    end
  end

  logic [1:0] fail_in, good_q, warn_q, good_n, warn_n, chg;
  assign fail_in = {batt_status[3], batt_status[1]};

  for (genvar i = 0; i < 2; i++) begin : g_batt
    logic [AW-1:0] age_q, age_n;
    logic          g_n, w_n, c_n;

    always_comb begin
      g_n   = good_q[i];
      w_n   = warn_q[i];
      c_n   = 1'b0;
      age_n = age_q;
      if (fail_in[i] == good_q[i]) begin
        g_n   = ~fail_in[i];
        c_n   = 1'b1;
        age_n = '0;
        if (!fail_in[i]) w_n = 1'b0;
      end else begin
        if (age_q != AW'(WARN_SAMPLES)) age_n = age_q + 1'b1;
        if (!good_q[i] && !warn_q[i] && age_n >= AW'(WARN_SAMPLES)) begin
          w_n = 1'b1;
          c_n = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)         age_q <= '0;
      else if (sample_go) age_q <= age_n;
    end

    assign good_n[i] = g_n;
    assign warn_n[i] = w_n;
    assign chg[i]    = c_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_q <= 2'b11;
      warn_q <= 2'b00;
    end else if (sample_go) begin
      good_q <= good_n;
      warn_q <= warn_n;
    end
  end

  logic [1:0] fault_code;
  always_comb begin
    if (&good_n)       fault_code = 2'd0;
    else if (|warn_n)  fault_code = 2'd1;
    else if (~|good_n) fault_code = 2'd3;
    else               fault_code = 2'd2;
  end

  logic [7:0] led_q, led_d;
  always_comb begin
    led_d = led_q;
    if (wr_en) begin
      case (wr_field)
        2'd0: led_d[3:2] = wr_toggle ? {led_q[3], ~led_q[2]} : wr_val;
        2'd1: led_d[5:4] = wr_toggle ? {led_q[5], ~led_q[4]} : wr_val;
        2'd2: led_d[7:6] = wr_toggle ? {led_q[7], ~led_q[6]} : wr_val;
        default: ;
      endcase
    end
    if (sample_go && |chg) led_d[5:4] = fault_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) led_q <= 8'h00;
    else        led_q <= led_d;
  end

  logic [FW-1:0] pre_q;
  logic [2:0]    step_q;
  logic          pre_hit, slow_on, fast_on;
  assign pre_hit = (pre_q == FW'(FLASH_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
    end else begin
      pre_q <= pre_hit ? '0 : pre_q + 1'b1;
      if (pre_hit) step_q <= step_q + 1'b1;
    end
  end

  assign slow_on = (step_q < 3'd3);
  assign fast_on = ~step_q[0];

  function automatic logic lamp_of(input logic [1:0] code, input logic inv);
    case (code)
      2'd0:    lamp_of = inv;
      2'd1:    lamp_of = ~inv;
      2'd2:    lamp_of = slow_on;
      default: lamp_of = fast_on;
    endcase
  endfunction

  assign led_byte    = led_q;
  assign remove_lamp = lamp_of(led_q[3:2], 1'b0);
  assign fault_lamp  = lamp_of(led_q[5:4], 1'b0);
  assign power_lamp  = lamp_of(led_q[7:6], 1'b1);
  assign batt_good   = good_q;
  assign batt_warned = warn_q;
endmodule

module batt_led_sup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_field,
  input logic       xfer_busy,
  input logic [7:0] led_byte,
  input logic [1:0] batt_good,
  input logic [1:0] batt_warned
);
  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    led_byte[1:0] == 2'b00);

  a_r2_sel3_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == 2'd3 && xfer_busy) |=> $stable(led_byte));

  a_r6_busy_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> ($stable(batt_good) && $stable(batt_warned)));

  a_r8_warned_only_failed: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_warned & batt_good) == 2'b00);

  a_r9_both_good_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(batt_good) && batt_good == 2'b11) |-> led_byte[5:4] == 2'b00);

  a_r9_warn_lights: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(batt_warned[0]) || $rose(batt_warned[1])) |-> led_byte[5:4] == 2'b01);
endmodule

bind batt_led_sup batt_led_sup_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_field(wr_field),
  .xfer_busy(xfer_busy), .led_byte(led_byte),
  .batt_good(batt_good), .batt_warned(batt_warned)
);

// File: tb/batt_led_sup_test.sv
`timescale 1ns/1ps
module batt_led_sup_test;
  localparam int TICK = 10;
  localparam int WARN = 3;
  localparam int FDIV = 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_toggle = 0, xfer_busy = 1;
  logic [1:0] wr_field = 0, wr_val = 0;
  logic [3:0] batt_status = 0;
  logic [7:0] led_byte;
  logic remove_lamp, fault_lamp, power_lamp;
  logic [1:0] batt_good, batt_warned;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  batt_led_sup #(.TICK_CYCLES(TICK), .WARN_SAMPLES(WARN), .FLASH_DIV(FDIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_field(wr_field),
    .wr_toggle(wr_toggle), .wr_val(wr_val), .xfer_busy(xfer_busy),
    .batt_status(batt_status), .led_byte(led_byte), .remove_lamp(remove_lamp),
    .fault_lamp(fault_lamp), .power_lamp(power_lamp),
    .batt_good(batt_good), .batt_warned(batt_warned));

  // {status, good, warned, fault code}
  localparam logic [9:0] VEC [15] = '{
    {4'h2, 2'b10, 2'b00, 2'd2}, {4'h2, 2'b10, 2'b00, 2'd2},
    {4'h2, 2'b10, 2'b00, 2'd2}, {4'h2, 2'b10, 2'b01, 2'd1},
    {4'hA, 2'b00, 2'b01, 2'd1}, {4'h8, 2'b01, 2'b00, 2'd2},
    {4'hD, 2'b01, 2'b00, 2'd2}, {4'hA, 2'b00, 2'b10, 2'd1},
    {4'hA, 2'b00, 2'b10, 2'd1}, {4'hA, 2'b00, 2'b10, 2'd1},
    {4'hA, 2'b00, 2'b11, 2'd1}, {4'h0, 2'b11, 2'b00, 2'd0},
    {4'h5, 2'b11, 2'b00, 2'd0}, {4'hA, 2'b00, 2'b00, 2'd3},
    {4'h0, 2'b11, 2'b00, 2'd0}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic one_sample(input logic [3:0] s);
    repeat (TICK + 2) @(negedge clk);
    batt_status = s;
    xfer_busy = 0;
    @(negedge clk);
    xfer_busy = 1;
  endtask

  task automatic host_wr(input logic [1:0] f, input logic t, input logic [1:0] v);
    @(negedge clk);
    wr_en = 1; wr_field = f; wr_toggle = t; wr_val = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic count_lit(input int which, output int n);
    n = 0;
    for (int k = 0; k < 8 * FDIV; k++) begin
      @(negedge clk);
      case (which)
        0: n += int'(remove_lamp);
        1: n += int'(fault_lamp);
        default: n += int'(power_lamp);
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset byte", 16'(led_byte), 16'h00);
    check("R8 reset state", 16'({batt_good, batt_warned}), 16'b1100);
    check("R4 reset lamps", 16'({power_lamp, fault_lamp, remove_lamp}), 16'b100);

    // R5 R7 R8 R9: sample sequence
    for (int i = 0; i < 15; i++) begin
      one_sample(VEC[i][9:6]);
      check($sformatf("R7/R8/R9 vector %0d", i),
            16'({batt_good, batt_warned, led_byte}),
            16'({VEC[i][5:2], 2'b00, VEC[i][1:0], 4'h0}));
    end

    host_wr(2'd0, 1'b0, 2'd2);
    check("R2 load remove", 16'(led_byte), 16'h08);
    host_wr(2'd0, 1'b1, 2'd0);
    check("R3 toggle remove", 16'(led_byte), 16'h0C);
    host_wr(2'd2, 1'b0, 2'd1);
    check("R2 load power", 16'(led_byte), 16'h4C);
    check("R4 power code1 dark", 16'(power_lamp), 16'd0);
    host_wr(2'd2, 1'b1, 2'd3);
    check("R3 toggle power", 16'(led_byte), 16'h0C);
    check("R4 power code0 lit", 16'(power_lamp), 16'd1);
    host_wr(2'd1, 1'b1, 2'd0);
    check("R3 toggle fault", 16'({led_byte, 7'd0, fault_lamp}), 16'h1C01);
    host_wr(2'd3, 1'b0, 2'd3);
    check("R2 select 3 ignored", 16'(led_byte), 16'h1C);

    one_sample(4'h5);
    check("R10 no change keeps host fault", 16'(led_byte), 16'h1C);

    // R6 deferral
    @(negedge clk);
    batt_status = 4'h2;
    repeat (3 * TICK) @(negedge clk);
    check("R6 busy defers sample", 16'(batt_good), 16'b11);
    xfer_busy = 0;
    @(negedge clk);
    xfer_busy = 1;
    check("R6 deferred sample taken", 16'({batt_good, led_byte}), 16'h22C);

    count_lit(1, n);
    check("R4 slow flash duty", 16'(n), 16'(3 * FDIV));
    count_lit(0, n);
    check("R4 fast flash duty", 16'(n), 16'(4 * FDIV));
    host_wr(2'd2, 1'b0, 2'd2);
    count_lit(2, n);
    check("R4 power slow flash", 16'(n), 16'(3 * FDIV));

    // R10 sample beats simultaneous host write to fault
    repeat (TICK + 2) @(negedge clk);
    batt_status = 4'hA; xfer_busy = 0;
    wr_en = 1; wr_field = 2'd1; wr_toggle = 0; wr_val = 2'd1;
    @(negedge clk);
    xfer_busy = 1; wr_en = 0;
    check("R10 sample wins over host", 16'(led_byte), 16'hBC);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule